// File: doc/BRIEF.md
# Cipher Block Input/Output Handshake Buffer

This block sits between a host register port and a 128-bit block cipher engine. The host writes one block into a four-word input buffer and hands it over by writing 0 to an input-ready flag. The block later reads the result from a four-word output buffer and frees that buffer by writing 0 to an output-ready flag. A 61-bit byte counter, loaded by a two-register length write, starts each context and counts down as the engine takes blocks. A context-ready flag and a saved-context-ready flag control when a new context may begin and when an authentication tag may be read.

The engine is modelled as a start/done pair with a fixed latency `ENG_LAT`. Its result is the presented block XOR the parameter `ENG_KEY`. There are three operating modes. Block mode needs whole 16-byte blocks. Counter mode accepts any byte count. Authentication mode chains blocks into a 128-bit tag and produces no data output.

The controller is a state machine with these states:
- ST_IDLE: context may be written.
- ST_FILL: host fills the input buffer.
- ST_PEND: block handed over, waiting for a free output buffer.
- ST_RUN: engine busy.
- ST_TAG: tag waiting to be read.

Its transitions are:
- IDLE→FILL: accepted length write.
- FILL→PEND: input-ready written 0.
- PEND→RUN: output buffer free, engine started.
- RUN→FILL: block done, bytes remain.
- RUN→IDLE: last block done, with no saved tag.
- RUN→TAG: last authentication block done with save enabled.
- TAG→IDLE: fourth tag word read, or clear bit written 1.

Top module: `cio_blk_buffer`

Register selects (`wr_sel`/`rd_sel`):
- 0..3: input words, holding bits 31:0 up to 127:96.
- 4..7: output words, in the same word order.
- 8..11: tag words, in the same word order.
- 12: control/status.
- 13: length low.
- 14: length high (bits 60:32 taken from data bits 28:0).

Control/status bits:
- bit 0: output-ready.
- bit 1: input-ready.
- bits 3:2: mode (0 = block, 1 = counter, 2 = authentication, 3 = block).
- bit 4: save-tag enable.
- bit 30: saved-context-ready, read-only except that writing 1 clears it.
- bit 31: context-ready, read-only.

Byte k of a block is bits 8k+7:8k.

## Requirements
- R1: After reset the status reads 0x8000_0000 (context-ready 1, all other flags 0) and the remaining length reads 0.
- R2: Context-ready and saved-context-ready are never 1 together.
- R3: A length-high write while context-ready is 1 loads the length {high[28:0], low}. It then clears context-ready and sets input-ready. Length writes made while context-ready is 0 leave the remaining length unchanged.
- R4: Writing 0 to control bit 1 while input-ready is 1 hands the block to the engine and clears the input buffer. Writing 1 to that bit changes nothing.
- R5: When the engine finishes a block in block or counter mode, output-ready becomes 1 and the output words hold the block XOR `ENG_KEY`. Writing 0 to bit 0 clears output-ready. Writing 1 to bit 0 changes nothing.
- R6: The engine starts only when input-ready is 0, a block is pending and output-ready is 0. A pending block waits, and the remaining length stays unchanged, until the previous output is released.
- R7: Each engine start reduces the remaining length by 16, or by the remainder if less than 16 bytes remain. After the final block completes (without a saved tag), context-ready is 1, input-ready is 0 and the remaining length is 0.
- R8: In block or counter mode a length of 0 means unbounded: the remaining length stays 0 and input-ready returns after every block.
- R9: A length that is not a multiple of 16 is refused in block mode, and a length of 0 is refused in authentication mode. A refused length leaves context-ready at 1 and input-ready at 0.
- R10: In counter mode the output bytes of a short final block at positions at or beyond the remaining byte count read 0.
- R11: In authentication mode each block, with bytes beyond the remaining count zeroed, is XORed with the running tag (0 at context start) and passed through the engine to form the new tag. Output-ready stays 0 throughout.
- R12: With save-tag enabled, the end of an authentication context sets saved-context-ready and keeps context-ready 0 until the fourth tag word is read; reading tag words 0 to 2 keeps it. With save-tag disabled, context-ready returns at once.
- R13: A control write with bit 30 set clears saved-context-ready and leaves mode and save-tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (side effect only on tag word 3) |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |

## Verification
The bench builds the block with `ENG_LAT` set to 3 and the default `LEN_W` of 61 and `ENG_KEY`. The short latency lets many contexts, including held-off and unbounded ones, run within the cycle budget. The full 61-bit length lets a write into the upper length register be seen as refused while a context runs. Counter-mode contexts use random byte counts, so short final blocks of every size from 1 to 15 bytes come within reach of the masking checks.

// File: rtl/cio_pkg.sv
package cio_pkg;
    localparam int CIO_WORD_W    = 32;
    localparam int CIO_WORDS     = 4;
    localparam int CIO_BLK_W     = CIO_WORD_W * CIO_WORDS;
    localparam int CIO_BLK_BYTES = CIO_BLK_W / 8;
    localparam int CIO_CNT_W     = $clog2(CIO_BLK_BYTES + 1);

    localparam logic [3:0] SEL_OUT0   = 4'd4;
    localparam logic [3:0] SEL_TAG0   = 4'd8;
    localparam logic [3:0] SEL_TAG3   = 4'd11;
    localparam logic [3:0] SEL_CTRL   = 4'd12;
    localparam logic [3:0] SEL_LEN_LO = 4'd13;
    localparam logic [3:0] SEL_LEN_HI = 4'd14;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FILL, ST_PEND, ST_RUN, ST_TAG
    } cio_state_e;

    typedef enum logic [1:0] {
        MD_BLOCK = 2'd0, MD_CTR = 2'd1, MD_AUTH = 2'd2, MD_BLOCK2 = 2'd3
    } cio_mode_e;

    // zero every byte at position n and above
    function automatic logic [CIO_BLK_W-1:0] keep_bytes(
        input logic [CIO_BLK_W-1:0] b, input logic [CIO_CNT_W-1:0] n);
        logic [CIO_BLK_W-1:0] r;
        r = b;
        for (int k = 0; k < CIO_BLK_BYTES; k++)
            if (k >= int'(n)) r[k*8 +: 8] = 8'h00;
        return r;
    endfunction
endpackage

// File: rtl/cio_engine.sv
module cio_engine #(
    parameter int BLK_W = 128,
    parameter int LAT   = 4,
    parameter logic [BLK_W-1:0] KEY = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] blk_in,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] blk_out
);
    localparam int CW = $clog2(LAT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
            blk_out <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                cnt     <= CW'(LAT);
                blk_out <= blk_in ^ KEY;
            end else if (busy) begin
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cio_len_ctr.sv
module cio_len_ctr #(
    parameter int LEN_W = 61,
    parameter int CNT_W = 5,
    parameter int BLK_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             take,
    output logic [LEN_W-1:0] remaining,
    output logic             unbounded,
    output logic [CNT_W-1:0] chunk,
    output logic             last
);
    logic big;
    assign big   = remaining >= LEN_W'(BLK_BYTES);
    assign chunk = (unbounded || big) ? CNT_W'(BLK_BYTES) : remaining[CNT_W-1:0];
    assign last  = !unbounded && !(remaining > LEN_W'(BLK_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
            unbounded <= 1'b0;
        end else if (load) begin
            remaining <= load_val;
            unbounded <= (load_val == '0);
        end else if (take && !unbounded) begin
            remaining <= remaining - LEN_W'(chunk);
        end
    end
endmodule

// File: rtl/cio_blk_buffer.sv
module cio_blk_buffer
    import cio_pkg::*;
#(
    parameter int LEN_W   = 61,
    parameter int ENG_LAT = 4,
    parameter logic [CIO_BLK_W-1:0] ENG_KEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [3:0]  rd_sel,
    output logic [31:0] rd_data
);
    localparam int HI_W = LEN_W - 32;

    cio_state_e state, state_n;
    cio_mode_e  mode_q;
    logic save_q, ctx_rdy, saved_rdy, in_rdy, out_rdy;
    logic [31:0] len_lo_q;
    logic [CIO_BLK_W-1:0] in_q, out_q, tag_q, eng_in, eng_out;
    logic [CIO_CNT_W-1:0] blk_bytes_q, chunk;
    logic blk_last_q, last, unbounded;
    logic [LEN_W-1:0] remaining, full_len;
    logic eng_busy, eng_done, eng_start;
    logic wr_ctrl, ctrl_plain, clr_saved, tag3_read, hi_write, len_ok;
    logic ctx_go, submit, blk_end, is_auth, end_saved, end_plain, tag_clear;

    // ---------------- decode ----------------
    assign wr_ctrl    = wr_en && wr_sel == SEL_CTRL;
    assign clr_saved  = wr_ctrl && wr_data[30];
    assign ctrl_plain = wr_ctrl && !wr_data[30];
    assign tag3_read  = rd_en && rd_sel == SEL_TAG3;
    assign hi_write   = wr_en && wr_sel == SEL_LEN_HI && ctx_rdy;
    assign full_len   = {wr_data[HI_W-1:0], len_lo_q};
    assign is_auth    = mode_q == MD_AUTH;

    always_comb begin
        unique case (mode_q)
            MD_CTR:  len_ok = 1'b1;
            MD_AUTH: len_ok = full_len != '0;
            default: len_ok = full_len[3:0] == 4'h0;
        endcase
    end

    assign ctx_go    = state == ST_IDLE && hi_write && len_ok;
    assign submit    = state == ST_FILL && ctrl_plain && !wr_data[1];
    assign eng_start = state == ST_PEND && !out_rdy;
    assign blk_end   = state == ST_RUN && eng_done;
    assign end_saved = blk_end && blk_last_q && is_auth && save_q;
    assign end_plain = blk_end && blk_last_q && !(is_auth && save_q);
    assign tag_clear = state == ST_TAG && (tag3_read || clr_saved);

    // ---------------- engine path ----------------
    assign eng_in = is_auth ? (keep_bytes(in_q, chunk) ^ tag_q) : in_q;

    cio_engine #(.BLK_W(CIO_BLK_W), .LAT(ENG_LAT), .KEY(ENG_KEY)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .blk_in(eng_in),
        .busy(eng_busy), .done(eng_done), .blk_out(eng_out)
    );

    cio_len_ctr #(.LEN_W(LEN_W), .CNT_W(CIO_CNT_W), .BLK_BYTES(CIO_BLK_BYTES)) u_len (
        .clk(clk), .rst_n(rst_n), .load(ctx_go), .load_val(full_len),
        .take(eng_start), .remaining(remaining), .unbounded(unbounded),
        .chunk(chunk), .last(last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (ctx_go)    state_n = ST_FILL;
            ST_FILL: if (submit)    state_n = ST_PEND;
            ST_PEND: if (eng_start) state_n = ST_RUN;
            ST_RUN:  if (eng_done)
                         state_n = !blk_last_q ? ST_FILL
                                 : (is_auth && save_q) ? ST_TAG : ST_IDLE;
            ST_TAG:  if (tag_clear) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // ---------------- outputs and buffers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= MD_BLOCK;
            save_q      <= 1'b0;
            len_lo_q    <= '0;
            in_q        <= '0;
            out_q       <= '0;
            tag_q       <= '0;
            blk_bytes_q <= '0;
            blk_last_q  <= 1'b0;
            ctx_rdy     <= 1'b1;
            saved_rdy   <= 1'b0;
            in_rdy      <= 1'b0;
            out_rdy     <= 1'b0;
        end else begin
            if (ctrl_plain && ctx_rdy) begin
                mode_q <= cio_mode_e'(wr_data[3:2]);
                save_q <= wr_data[4];
            end
            if (wr_en && wr_sel == SEL_LEN_LO && ctx_rdy) len_lo_q <= wr_data;

            for (int i = 0; i < CIO_WORDS; i++) begin
                if (eng_start)
                    in_q[i*CIO_WORD_W +: CIO_WORD_W] <= '0;
                else if (wr_en && wr_sel == 4'(i))
                    in_q[i*CIO_WORD_W +: CIO_WORD_W] <= wr_data;
            end

            if (eng_start) begin
                blk_bytes_q <= chunk;
                blk_last_q  <= last;
            end

            if (ctx_go)                 tag_q <= '0;
            else if (blk_end && is_auth) tag_q <= eng_out;

            if (blk_end && !is_auth)
                out_q <= (mode_q == MD_CTR) ? keep_bytes(eng_out, blk_bytes_q) : eng_out;

            if (ctx_go)                       ctx_rdy <= 1'b0;
            else if (end_plain || tag_clear)  ctx_rdy <= 1'b1;

            if (end_saved)      saved_rdy <= 1'b1;
            else if (tag_clear) saved_rdy <= 1'b0;

            if (ctx_go || (blk_end && !blk_last_q)) in_rdy <= 1'b1;
            else if (submit)                        in_rdy <= 1'b0;

            if (blk_end && !is_auth)              out_rdy <= 1'b1;
            else if (ctrl_plain && !wr_data[0])   out_rdy <= 1'b0;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd_data = '0;
        unique case (rd_sel[3:2])
            2'b01: rd_data = out_q[rd_sel[1:0]*CIO_WORD_W +: CIO_WORD_W];
            2'b10: rd_data = tag_q[rd_sel[1:0]*CIO_WORD_W +: CIO_WORD_W];
            2'b11: begin
                if (rd_sel == SEL_CTRL)
                    rd_data = {ctx_rdy, saved_rdy, 25'd0, save_q, mode_q, in_rdy, out_rdy};
                else if (rd_sel == SEL_LEN_LO)
                    rd_data = remaining[31:0];
                else if (rd_sel == SEL_LEN_HI)
                    rd_data = {{(64-LEN_W){1'b0}}, remaining[LEN_W-1:32]};
            end
            default: rd_data = '0;
        endcase
    end

    // ---------------- assertions ----------------
    a_r2_ctx_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctx_rdy && saved_rdy));

    a_r4_in_ignore_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_data[1] && in_rdy) |=> in_rdy);

    a_r5_out_ignore_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_data[0] && out_rdy) |=> out_rdy);

    a_r6_engine_guard: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> (!in_rdy && !out_rdy));

    a_r12_tag_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (saved_rdy && tag3_read) |=> (!saved_rdy && ctx_rdy));

    a_r3_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_rdy && !eng_start) |=> $stable(remaining));
endmodule

// File: tb/cio_blk_buffer_test.sv
module cio_blk_buffer_test;
    import cio_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] KEY = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] wr_sel = '0, rd_sel = '0;
    logic [31:0] wr_data = '0, rd_data;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cio_blk_buffer #(.ENG_LAT(3)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [127:0] keep(input logic [127:0] b, input int n);
        logic [127:0] r = b;
        for (int k = 0; k < 16; k++) if (k >= n) r[k*8 +: 8] = 8'h00;
        return r;
    endfunction

    function automatic logic [127:0] rnd_blk();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = s;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_blk(input logic [3:0] base, output logic [127:0] b);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            rd(base + 4'(i), w);
            b[i*32 +: 32] = w;
        end
    endtask

    task automatic status(output logic [31:0] s);
        rd(SEL_CTRL, s);
    endtask

    task automatic remaining(output logic [63:0] r);
        logic [31:0] lo, hi;
        rd(SEL_LEN_LO, lo);
        rd(SEL_LEN_HI, hi);
        r = {hi, lo};
    endtask

    // wait until any bit of mask is set in status
    task automatic wait_any(input logic [31:0] mask, input string req);
        logic [31:0] s;
        for (int t = 0; t < 300; t++) begin
            status(s);
            if ((s & mask) != 0) return;
        end
        check(req, 128'(s & mask), 128'(mask));
    endtask

    task automatic setup(input int md, input bit save, input logic [63:0] len);
        wr(SEL_CTRL, {27'd0, save, 2'(md), 2'b11});
        wr(SEL_LEN_LO, len[31:0]);
        wr(SEL_LEN_HI, len[63:32]);
    endtask

    task automatic put_blk(input logic [127:0] b);
        for (int i = 0; i < 4; i++) wr(4'(i), b[i*32 +: 32]);
        wr(SEL_CTRL, 32'h0000_0001);  // bit1=0 hands over, bit0=1 ignored
    endtask

    // one block or counter-mode context with full checking
    task automatic run_basic(input int md, input int len, input string req);
        logic [127:0] b, got;
        logic [63:0] r;
        logic [31:0] s;
        int left = len;
        while (left > 0) begin
            int n = (left >= 16) ? 16 : left;
            wait_any(32'h2, req);
            b = rnd_blk();
            put_blk(b);
            wait_any(32'h1, req);
            rd_blk(SEL_OUT0, got);
            check({req, " data"}, got, (md == 1) ? keep(b ^ KEY, n) : (b ^ KEY));
            left -= n;
            remaining(r);
            check("R7 remaining", 128'(r), 128'(left));
            wr(SEL_CTRL, 32'h0000_0002);  // release output
        end
        status(s);
        check("R7 end flags", 128'(s[31:30]), 128'(2'b10));
        check("R7 in_rdy low", 128'(s[1]), 128'(0));
    endtask

    task automatic run_auth(input bit save, input int len, output logic [127:0] tag);
        logic [127:0] b;
        logic [31:0] s;
        int left = len;
        tag = '0;
        while (left > 0) begin
            int n = (left >= 16) ? 16 : left;
            wait_any(32'h2, "R11");
            b = rnd_blk();
            put_blk(b);
            tag = (keep(b, n) ^ tag) ^ KEY;
            left -= n;
            wait_any(32'hC000_0002, "R11");
            status(s);
            check("R11 no output", 128'(s[0]), 128'(0));
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] s;
        logic [63:0] r;
        logic [127:0] b1, b2, got, tag;
        void'($urandom(32'd31337));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        status(s);
        check("R1 status", 128'(s), 128'(32'h8000_0000));
        remaining(r);
        check("R1 remaining", 128'(r), 128'(0));

        // R3 start, R4/R5/R6 handshake in block mode, 48 bytes
        setup(0, 1'b0, 64'd48);
        status(s);
        check("R3 ctx cleared, in set", 128'({s[31], s[1]}), 128'(2'b01));
        check("R2 exclusive", 128'(s[31] & s[30]), 128'(0));
        wr(SEL_LEN_LO, 32'd999);
        wr(SEL_LEN_HI, 32'd5);
        remaining(r);
        check("R3 locked length", 128'(r), 128'(48));
        b1 = rnd_blk();
        for (int i = 0; i < 4; i++) wr(4'(i), b1[i*32 +: 32]);
        wr(SEL_CTRL, 32'h0000_0003);
        repeat (10) @(negedge clk);
        status(s);
        check("R4 write 1 ignored", 128'(s[1:0]), 128'(2'b10));
        remaining(r);
        check("R4 no start", 128'(r), 128'(48));
        wr(SEL_CTRL, 32'h0000_0001);
        wait_any(32'h1, "R5");
        rd_blk(SEL_OUT0, got);
        check("R5 result", got, b1 ^ KEY);
        wr(SEL_CTRL, 32'h0000_0003);
        status(s);
        check("R5 write 1 ignored", 128'(s[0]), 128'(1));
        // R6: second block waits behind unreleased output
        wait_any(32'h2, "R6");
        b2 = rnd_blk();
        for (int i = 0; i < 4; i++) wr(4'(i), b2[i*32 +: 32]);
        wr(SEL_CTRL, 32'h0000_0001);  // bit0=1 keeps output
        repeat (15) @(negedge clk);
        rd_blk(SEL_OUT0, got);
        check("R6 output held", got, b1 ^ KEY);
        remaining(r);
        check("R6 no take", 128'(r), 128'(32));
        wr(SEL_CTRL, 32'h0000_0002);
        wait_any(32'h1, "R6");
        rd_blk(SEL_OUT0, got);
        check("R6 second result", got, b2 ^ KEY);
        wr(SEL_CTRL, 32'h0000_0002);
        run_basic(0, 16, "R7");

        // R4 partial block: unwritten words read back as zero after handover
        setup(0, 1'b0, 64'd16);
        b1 = rnd_blk();
        wr(4'd0, b1[31:0]);
        wr(SEL_CTRL, 32'h0000_0001);
        wait_any(32'h1, "R4");
        rd_blk(SEL_OUT0, got);
        check("R4 cleared buffer", got, {96'd0, b1[31:0]} ^ KEY);
        wr(SEL_CTRL, 32'h0000_0002);

        // R9 refused lengths
        setup(0, 1'b0, 64'd20);
        status(s);
        check("R9 block non-multiple", 128'({s[31], s[1]}), 128'(2'b10));
        setup(2, 1'b0, 64'd0);
        status(s);
        check("R9 auth zero", 128'({s[31], s[1]}), 128'(2'b10));

        // R10 counter mode, directed short tail then random lengths
        setup(1, 1'b0, 64'd21);
        run_basic(1, 21, "R10");
        for (int k = 0; k < 12; k++) begin
            int len = 1 + int'($urandom % 64);
            setup(1, 1'b0, 64'(len));
            run_basic(1, len, "R10");
        end
        for (int k = 0; k < 4; k++) begin
            int len = 16 * (1 + int'($urandom % 4));
            setup(0, 1'b0, 64'(len));
            run_basic(0, len, "R7");
        end

        // R8 unbounded counter mode
        setup(1, 1'b0, 64'd0);
        for (int k = 0; k < 3; k++) begin
            wait_any(32'h2, "R8");
            b1 = rnd_blk();
            put_blk(b1);
            wait_any(32'h1, "R8");
            rd_blk(SEL_OUT0, got);
            check("R8 data", got, b1 ^ KEY);
            wr(SEL_CTRL, 32'h0000_0002);
        end
        wait_any(32'h2, "R8");
        status(s);
        check("R8 still running", 128'({s[31], s[1]}), 128'(2'b01));
        remaining(r);
        check("R8 remaining zero", 128'(r), 128'(0));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R11/R12 auth with save, cleared by 4th tag read
        setup(2, 1'b1, 64'd40);
        run_auth(1'b1, 40, tag);
        status(s);
        check("R12 saved set", 128'(s[31:30]), 128'(2'b01));
        rd_blk(SEL_TAG0, got);
        check("R11 tag", got, tag);
        status(s);
        check("R12 cleared by 4th read", 128'(s[31:30]), 128'(2'b10));

        // R12 partial reads keep the flag; R13 write-1 clear ignores fields
        setup(2, 1'b1, 64'd16);
        run_auth(1'b1, 16, tag);
        rd(SEL_TAG0, s);
        rd(SEL_TAG0 + 4'd2, s);
        status(s);
        check("R12 held after partial reads", 128'(s[31:30]), 128'(2'b01));
        wr(SEL_CTRL, 32'h4000_0007);
        status(s);
        check("R13 clear", 128'(s[31:30]), 128'(2'b10));
        check("R13 fields kept", 128'(s[4:2]), 128'(3'b110));

        // R12 without save: context ready at once
        setup(2, 1'b0, 64'd33);
        run_auth(1'b0, 33, tag);
        status(s);
        check("R12 no save", 128'(s[31:30]), 128'(2'b10));
        rd_blk(SEL_TAG0, got);
        check("R11 tag no save", got, tag);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule